// File: doc/BRIEF.md
# Prioritized Triple CAN Transmit Buffer

This block manages the transmit side of a CAN controller between the CPU and the bit engine. It holds three message slots. Each slot stores a 13-byte frame image (identifier, control and data bytes) and one local priority byte. The CPU reaches every slot through one shared register window. It first writes a one-hot select register to choose the slot the window shows, fills the bytes, and then queues the slot by clearing its empty flag.

On the bus side the block offers one frame at a time on a valid/ready stream. Once the offer has been raised, the offered slot, its index and its bytes stay fixed until the bus side accepts them. Back-pressure is therefore plain: while `tx_ready` is low, nothing on the offer changes. After acceptance the slot stays locked until the bus side reports `tx_done` or `tx_lost`. A completed slot becomes empty again. A slot that lost arbitration stays queued, and the choice of slot is made again. When another slot is pending, the next offer follows a completion with no idle cycle, so the node keeps contending for the bus. A per-slot enable masks the empty flags onto one interrupt line.

Top module: `can_tx_queue`

## Requirements
- R1: After reset all three empty flags read 1, the select and enable registers read 0, `tx_valid` is 0 and `tx_irq` is 0.
- R2: A write to the select register (address 0x12, bit i names slot i) keeps only the lowest set bit whose slot is empty. The register reads back that one-hot value, or 0 when no set bit qualifies.
- R3: Window addresses 0 to 12 reach frame bytes 0 to 12 of the selected slot, and address 13 reaches its priority byte. Reads return the stored value. With no slot selected, reads return 0 and writes do nothing.
- R4: The flag register (address 0x10, bit i is slot i, 1 means empty) is write-one-to-clear. Writing a 0 bit leaves that flag unchanged.
- R5: `tx_valid` rises two clock edges after a flag-clearing write. It offers the queued slot with the lowest priority byte, and on a tie the slot with the lower index. `tx_buf` carries the slot index and `tx_frame` carries its bytes, byte 0 in bits 7:0.
- R6: From the moment a slot is offered until the bus side releases it, CPU window writes to that slot and flag writes to that slot are ignored. Once the offer is accepted, `tx_valid` is low.
- R7: `tx_done` sets the empty flag of the busy slot. If another slot is queued, the next offer is visible right after the same edge. If none is queued, `tx_valid` stays low.
- R8: `tx_lost` releases the busy slot but leaves it queued. The selection runs again among all queued slots, so a higher-priority slot queued in the meantime is offered first.
- R9: `tx_irq` is high exactly when some slot has both its empty flag and its enable bit set. The enable register is at address 0x11, bit i for slot i.
- R10: While `tx_valid` is high and `tx_ready` is low, `tx_valid`, `tx_buf` and `tx_frame` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_wr | input | 1 | CPU write strobe for this cycle |
| cpu_addr | input | 5 | CPU register address (window 0-13, registers 0x10-0x12) |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Combinational read data for `cpu_addr` |
| tx_valid | output | 1 | A frame is offered to the bus side |
| tx_ready | input | 1 | Bus side accepts the offered frame |
| tx_buf | output | 2 | Index of the offered slot |
| tx_frame | output | 104 | Bytes of the offered frame, byte 0 in bits 7:0 |
| tx_done | input | 1 | Busy frame was sent successfully |
| tx_lost | input | 1 | Busy frame lost arbitration or hit an error |
| tx_irq | output | 1 | Transmit interrupt |

## Verification
Register writes take effect at the edge that samples them, so readback, flag and interrupt values are sampled at the following falling edge. An offer appears one edge after the flag changes, so the bench waits two falling edges after a queueing write. After a done or lost pulse, the next offer is already present at the very next falling edge, and the bench samples it there to prove there is no idle gap. Acceptance is likewise checked one falling edge after `tx_ready`, where `tx_valid` must be low.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;
  localparam int BYTE_W = 8;
  localparam int PRIO_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_BUSY  = 2'd2
  } txq_state_e;
endpackage

// File: rtl/can_txq_ctrl.sv
module can_txq_ctrl #(
  parameter int NUM_BUF = 3,
  parameter int AW = 5,
  parameter int IW = 2,
  parameter logic [AW-1:0] FLAG_ADDR = '0,
  parameter logic [AW-1:0] IEN_ADDR = '0,
  parameter logic [AW-1:0] SEL_ADDR = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [AW-1:0]      addr,
  input  logic [NUM_BUF-1:0] wdata,
  input  logic               lock_vld,
  input  logic [IW-1:0]      lock_idx,
  input  logic               done_set,
  input  logic [IW-1:0]      done_idx,
  output logic [NUM_BUF-1:0] empty_q,
  output logic [NUM_BUF-1:0] ien_q,
  output logic [NUM_BUF-1:0] sel_q
);
  logic flag_wr, ien_wr, sel_wr;
  logic [NUM_BUF-1:0] sel_pick;

  assign flag_wr = wr_en && (addr == FLAG_ADDR);
  assign ien_wr  = wr_en && (addr == IEN_ADDR);
  assign sel_wr  = wr_en && (addr == SEL_ADDR);

  // lowest requested slot that is empty wins
  always_comb begin
    sel_pick = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (wdata[i] && empty_q[i]) begin
        sel_pick = '0;
        sel_pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      empty_q <= '1;
      ien_q   <= '0;
      sel_q   <= '0;
    end else begin
      for (int i = 0; i < NUM_BUF; i++) begin
        if (done_set && done_idx == IW'(i))
          empty_q[i] <= 1'b1;
        else if (flag_wr && wdata[i] && !(lock_vld && lock_idx == IW'(i)))
          empty_q[i] <= 1'b0;
      end
      if (ien_wr) ien_q <= wdata;
      if (sel_wr) sel_q <= sel_pick;
    end
  end

  a_r2_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));

  a_r4_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && wdata == '0) |=> ((empty_q & $past(empty_q)) == $past(empty_q)));

  a_r6_locked_is_queued: assert property (@(posedge clk) disable iff (!rst_n)
    lock_vld |-> !empty_q[lock_idx]);

  a_r7_done_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    done_set |=> empty_q[$past(done_idx)]);
endmodule

// File: rtl/can_txq_store.sv
module can_txq_store #(
  parameter int NUM_BUF = 3,
  parameter int FRAME_BYTES = 13,
  parameter int IW = 2,
  parameter int OW = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IW-1:0]                     wr_buf,
  input  logic [OW-1:0]                     wr_off,
  input  logic [can_txq_pkg::BYTE_W-1:0]    wr_data,
  input  logic [IW-1:0]                     rd_buf,
  input  logic [OW-1:0]                     rd_off,
  output logic [can_txq_pkg::BYTE_W-1:0]    rd_data,
  input  logic [IW-1:0]                     tx_idx,
  output logic [FRAME_BYTES*can_txq_pkg::BYTE_W-1:0] tx_frame,
  output logic [NUM_BUF*can_txq_pkg::PRIO_W-1:0]     prio_flat
);
  import can_txq_pkg::*;
  localparam int SLOTS = FRAME_BYTES + 1;

  logic [BYTE_W-1:0] mem [NUM_BUF][SLOTS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BUF; b++)
        for (int s = 0; s < SLOTS; s++)
          mem[b][s] <= '0;
    end else if (wr_en) begin
      for (int b = 0; b < NUM_BUF; b++)
        for (int s = 0; s < SLOTS; s++)
          if (wr_buf == IW'(b) && wr_off == OW'(s))
            mem[b][s] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NUM_BUF; b++)
      for (int s = 0; s < SLOTS; s++)
        if (rd_buf == IW'(b) && rd_off == OW'(s))
          rd_data = mem[b][s];
  end

  always_comb begin
    tx_frame = '0;
    for (int b = 0; b < NUM_BUF; b++)
      if (tx_idx == IW'(b))
        for (int s = 0; s < FRAME_BYTES; s++)
          tx_frame[s*BYTE_W +: BYTE_W] = mem[b][s];
  end

  generate
    for (genvar g = 0; g < NUM_BUF; g++) begin : g_prio
      assign prio_flat[g*PRIO_W +: PRIO_W] = mem[g][FRAME_BYTES][PRIO_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/can_txq_arb.sv
module can_txq_arb #(
  parameter int NUM_BUF = 3,
  parameter int IW = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_BUF-1:0]    empty_q,
  input  logic [NUM_BUF*can_txq_pkg::PRIO_W-1:0] prio_flat,
  input  logic                  tx_ready,
  input  logic                  tx_done,
  input  logic                  tx_lost,
  output logic                  tx_valid,
  output logic                  lock_vld,
  output logic [IW-1:0]         lock_idx,
  output logic                  done_set
);
  import can_txq_pkg::*;

  txq_state_e state_q, state_d;
  logic [IW-1:0] lock_q, lock_d;
  logic [NUM_BUF-1:0] cand;
  logic pick_vld;
  logic [IW-1:0] pick_idx;
  logic [PRIO_W-1:0] best_p;
  logic release_now;

  assign release_now = (state_q == ST_BUSY) && (tx_done || tx_lost);

  // candidates: queued slots, minus the one finishing this cycle
  always_comb begin
    cand = ~empty_q;
    if (state_q == ST_BUSY && tx_done) cand[lock_q] = 1'b0;
    pick_vld = 1'b0;
    pick_idx = '0;
    best_p   = '1;
    for (int i = 0; i < NUM_BUF; i++) begin
      if (cand[i] && (!pick_vld || prio_flat[i*PRIO_W +: PRIO_W] < best_p)) begin
        pick_vld = 1'b1;
        pick_idx = IW'(i);
        best_p   = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end

  always_comb begin
    state_d = state_q;
    lock_d  = lock_q;
    unique case (state_q)
      ST_IDLE: if (pick_vld) begin
        state_d = ST_OFFER;
        lock_d  = pick_idx;
      end
      ST_OFFER: if (tx_ready) state_d = ST_BUSY;
      ST_BUSY: if (release_now) begin
        if (pick_vld) begin
          state_d = ST_OFFER;
          lock_d  = pick_idx;
        end else begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lock_q  <= '0;
    end else begin
      state_q <= state_d;
      lock_q  <= lock_d;
    end
  end

  assign tx_valid = (state_q == ST_OFFER);
  assign lock_vld = (state_q != ST_IDLE);
  assign lock_idx = lock_q;
  assign done_set = (state_q == ST_BUSY) && tx_done;

  a_r10_offer_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(lock_idx)));

  a_r5_offer_is_queued: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !empty_q[lock_idx]);

  a_r6_accept_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_valid);
endmodule

// File: rtl/can_tx_queue.sv
module can_tx_queue #(
  parameter int NUM_BUF = 3,
  parameter int FRAME_BYTES = 13,
  localparam int OW = $clog2(FRAME_BYTES + 1),
  localparam int AW = OW + 1,
  localparam int IW = $clog2(NUM_BUF)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_wr,
  input  logic [AW-1:0]            cpu_addr,
  input  logic [7:0]               cpu_wdata,
  output logic [7:0]               cpu_rdata,
  output logic                     tx_valid,
  input  logic                     tx_ready,
  output logic [IW-1:0]            tx_buf,
  output logic [FRAME_BYTES*8-1:0] tx_frame,
  input  logic                     tx_done,
  input  logic                     tx_lost,
  output logic                     tx_irq
);
  import can_txq_pkg::*;

  localparam int SLOTS = FRAME_BYTES + 1;
  localparam int REG_BASE = 1 << OW;
  localparam logic [AW-1:0] FLAG_ADDR = AW'(REG_BASE);
  localparam logic [AW-1:0] IEN_ADDR  = AW'(REG_BASE + 1);
  localparam logic [AW-1:0] SEL_ADDR  = AW'(REG_BASE + 2);

  logic [NUM_BUF-1:0] empty_q, ien_q, sel_q;
  logic lock_vld, done_set;
  logic [IW-1:0] lock_idx, sel_idx;
  logic sel_any, win_hit, win_wr;
  logic [BYTE_W-1:0] win_rd;
  logic [NUM_BUF*PRIO_W-1:0] prio_flat;

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NUM_BUF; i++)
      if (sel_q[i]) sel_idx = IW'(i);
  end

  assign sel_any = |sel_q;
  assign win_hit = cpu_addr < AW'(SLOTS);
  assign win_wr  = cpu_wr && win_hit && sel_any && !(lock_vld && lock_idx == sel_idx);

  can_txq_ctrl #(
    .NUM_BUF(NUM_BUF), .AW(AW), .IW(IW),
    .FLAG_ADDR(FLAG_ADDR), .IEN_ADDR(IEN_ADDR), .SEL_ADDR(SEL_ADDR)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(cpu_wr), .addr(cpu_addr),
    .wdata(cpu_wdata[NUM_BUF-1:0]), .lock_vld(lock_vld), .lock_idx(lock_idx),
    .done_set(done_set), .done_idx(lock_idx),
    .empty_q(empty_q), .ien_q(ien_q), .sel_q(sel_q)
  );

  can_txq_store #(
    .NUM_BUF(NUM_BUF), .FRAME_BYTES(FRAME_BYTES), .IW(IW), .OW(OW)
  ) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(win_wr), .wr_buf(sel_idx),
    .wr_off(cpu_addr[OW-1:0]), .wr_data(cpu_wdata), .rd_buf(sel_idx),
    .rd_off(cpu_addr[OW-1:0]), .rd_data(win_rd), .tx_idx(lock_idx),
    .tx_frame(tx_frame), .prio_flat(prio_flat)
  );

  can_txq_arb #(.NUM_BUF(NUM_BUF), .IW(IW)) u_arb (
    .clk(clk), .rst_n(rst_n), .empty_q(empty_q), .prio_flat(prio_flat),
    .tx_ready(tx_ready), .tx_done(tx_done), .tx_lost(tx_lost),
    .tx_valid(tx_valid), .lock_vld(lock_vld), .lock_idx(lock_idx),
    .done_set(done_set)
  );

  assign tx_buf = lock_idx;
  assign tx_irq = |(empty_q & ien_q);

  always_comb begin
    cpu_rdata = '0;
    if (win_hit) begin
      if (sel_any) cpu_rdata = win_rd;
    end else if (cpu_addr == FLAG_ADDR) begin
      cpu_rdata[NUM_BUF-1:0] = empty_q;
    end else if (cpu_addr == IEN_ADDR) begin
      cpu_rdata[NUM_BUF-1:0] = ien_q;
    end else if (cpu_addr == SEL_ADDR) begin
      cpu_rdata[NUM_BUF-1:0] = sel_q;
    end
  end

  a_r10_frame_held: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> $stable(tx_frame));
endmodule

// File: tb/can_tx_queue_bench.sv
module can_tx_queue_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [4:0] FLAGS = 5'h10;
  localparam logic [4:0] IEN   = 5'h11;
  localparam logic [4:0] SEL   = 5'h12;
  localparam int NVEC = 6;
  // {prio0, prio1, prio2, queue mask, order0, order1, order2}; order 3 = none
  localparam logic [32:0] VEC [NVEC] = '{
    {8'd5,   8'd3,   8'd9,  3'b111, 2'd1, 2'd0, 2'd2},
    {8'd7,   8'd7,   8'd7,  3'b111, 2'd0, 2'd1, 2'd2},
    {8'd0,   8'd255, 8'd0,  3'b110, 2'd2, 2'd1, 2'd3},
    {8'd200, 8'd100, 8'd50, 3'b101, 2'd2, 2'd0, 2'd3},
    {8'd1,   8'd2,   8'd3,  3'b010, 2'd1, 2'd3, 2'd3},
    {8'd255, 8'd255, 8'd0,  3'b011, 2'd0, 2'd1, 2'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_wr = 1'b0;
  logic [4:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] cpu_rdata;
  logic tx_valid, tx_irq;
  logic tx_ready = 1'b0, tx_done = 1'b0, tx_lost = 1'b0;
  logic [1:0] tx_buf;
  logic [103:0] tx_frame;
  int total = 0, bad = 0;
  logic [7:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  can_tx_queue u_can_tx_queue (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_buf(tx_buf), .tx_frame(tx_frame),
    .tx_done(tx_done), .tx_lost(tx_lost), .tx_irq(tx_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(posedge clk); #1;
    cpu_wr = 1'b0;
  endtask

  task automatic rdreg(input logic [4:0] a, output logic [7:0] d);
    cpu_addr = a;
    #1;
    d = cpu_rdata;
  endtask

  task automatic load(input int b, input logic [7:0] p);
    wr(SEL, 8'(1 << b));
    for (int k = 0; k < 13; k++) wr(5'(k), 8'(16*(b+1) + k));
    wr(5'd13, p);
  endtask

  // called at a falling edge with an offer present; returns at the falling edge after done
  task automatic accept_done();
    tx_ready = 1'b1;
    @(posedge clk); #1; tx_ready = 1'b0;
    @(negedge clk);
    chk("R6 valid low after accept", tx_valid, 0);
    tx_done = 1'b1;
    @(posedge clk); #1; tx_done = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rdreg(FLAGS, rd); chk("R1 flags", rd, 8'h07);
    rdreg(SEL, rd);   chk("R1 select", rd, 0);
    rdreg(IEN, rd);   chk("R1 enable", rd, 0);
    chk("R1 valid", tx_valid, 0);
    chk("R1 irq", tx_irq, 0);

    // vector walk: R5 priority order, R7 back-to-back drain
    for (int v = 0; v < NVEC; v++) begin
      automatic logic [32:0] e = VEC[v];
      load(0, e[32:25]); load(1, e[24:17]); load(2, e[16:9]);
      wr(FLAGS, {5'b0, e[8:6]});
      @(negedge clk); @(negedge clk);
      for (int k = 0; k < 3; k++) begin
        automatic logic [1:0] b = e[5-2*k -: 2];
        if (b != 2'd3) begin
          chk("R5 valid", tx_valid, 1);
          chk("R5 order", tx_buf, b);
          chk("R5 frame byte0", tx_frame[7:0], 16*(b+1));
          chk("R5 frame byte12", tx_frame[103:96], 16*(b+1) + 12);
          accept_done();
          rdreg(FLAGS, rd); chk("R7 flag set", rd[b], 1);
        end
      end
      chk("R7 idle after drain", tx_valid, 0);
    end

    // R2 select
    wr(SEL, 8'b110); rdreg(SEL, rd); chk("R2 lowest empty", rd, 8'b010);
    wr(SEL, 8'b000); rdreg(SEL, rd); chk("R2 zero", rd, 0);
    // R3 window
    wr(SEL, 8'b100);
    wr(5'd5, 8'h5A); rdreg(5'd5, rd); chk("R3 byte", rd, 8'h5A);
    wr(5'd13, 8'h33); rdreg(5'd13, rd); chk("R3 prio", rd, 8'h33);
    wr(SEL, 8'b010); rdreg(5'd5, rd); chk("R3 mapping", rd, 8'h25);
    // R4 zero write
    wr(FLAGS, 8'h00); rdreg(FLAGS, rd); chk("R4 zero keeps", rd, 8'h07);

    // R6 lock, R10 back-pressure, R2 none qualifies
    load(0, 8'd4);
    wr(FLAGS, 8'b001); rdreg(FLAGS, rd); chk("R4 clear", rd, 8'h06);
    @(negedge clk); @(negedge clk);
    chk("R5 single offer", tx_valid, 1);
    wr(5'd0, 8'hEE);
    @(negedge clk);
    rdreg(5'd0, rd); chk("R6 locked window", rd, 8'h10);
    chk("R6 locked frame", tx_frame[7:0], 8'h10);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R10 valid held", tx_valid, 1);
      chk("R10 index held", tx_buf, 0);
    end
    wr(SEL, 8'b001); rdreg(SEL, rd); chk("R2 none qualifies", rd, 0);
    @(negedge clk);
    accept_done();
    rdreg(FLAGS, rd); chk("R7 drained", rd, 8'h07);

    // R8 lost arbitration with reselection
    load(0, 8'd9); load(1, 8'd2);
    wr(FLAGS, 8'b001);
    @(negedge clk); @(negedge clk);
    tx_ready = 1'b1; @(posedge clk); #1; tx_ready = 1'b0;
    wr(FLAGS, 8'b010);
    @(negedge clk);
    tx_lost = 1'b1; @(posedge clk); #1; tx_lost = 1'b0;
    @(negedge clk);
    chk("R8 reoffer", tx_valid, 1);
    chk("R8 higher first", tx_buf, 1);
    rdreg(FLAGS, rd); chk("R8 stays queued", rd, 8'h04);
    accept_done();
    chk("R7 next immediate", tx_valid, 1);
    chk("R8 retry slot", tx_buf, 0);
    accept_done();
    rdreg(FLAGS, rd); chk("R8 all done", rd, 8'h07);

    // R9 interrupt
    wr(IEN, 8'b001); @(negedge clk); chk("R9 irq on", tx_irq, 1);
    wr(IEN, 8'b000); @(negedge clk); chk("R9 irq off", tx_irq, 0);
    wr(IEN, 8'b010);
    wr(FLAGS, 8'b010);
    @(negedge clk); chk("R9 queued no irq", tx_irq, 0);
    @(negedge clk);
    accept_done();
    chk("R9 irq after done", tx_irq, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule